// File: doc/BRIEF.md
# Flyback Peak/Valley Switch Controller

This block is the digital cycle controller of a current-limited flyback capacitor charger. It turns the power-switch gate on and off from two comparator flags and has no oscillator. One flag reports that primary current has reached its peak limit, which turns the switch off. The other reports that secondary current has decayed below its floor, which turns the switch back on. On-time and off-time therefore follow the transformer's own currents, so the core stays in continuous conduction for the whole charge.

The output voltage is sensed from the flyback pulse, so it can only be seen while the switch is off. After every turn-off the block opens a blanking window of a set number of clocks. During that window the raw voltage-detect flag is masked, so the leakage spike cannot trip it. The block also holds the switch off for a minimum number of clocks, so that the off phase always lasts long enough for sensing. A qualified detect becomes a one-clock pulse and halts switching. A mode controller then drops the enable to end the charge, or toggles it to start a new one.

Top module: `flyback_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, gateOn and targetReached are 0.
- R2: When enabled and not halted, with the gate off, valleyLow high, peakHit low and the minimum off time met, gateOn goes high at the next clock edge.
- R3: When gateOn is high and peakHit is high at a clock edge, gateOn is low after that edge, and a blanking window of BLANK_CYCLES clocks starts.
- R4: When peakHit and valleyLow are both high, turn-off wins: the gate goes off, or stays off, for as long as peakHit stays high.
- R5: Once the gate turns off, it stays off for at least MIN_OFF_CYCLES clock cycles, whatever valleyLow does. This also holds after reset and after re-enable.
- R6: A vdetRaw high in any of the BLANK_CYCLES cycles that follow a turn-off edge is ignored.
- R7: A vdetRaw high while the gate is on is ignored.
- R8: A vdetRaw high while the gate is off and outside the blanking window gives targetReached high for exactly one cycle after the next edge. From then on the gate stays off until enable is lowered.
- R9: Lowering enable forces gateOn low in the same cycle, with no clock edge needed. It also clears the halt, the off-time count and the blanking timer, so the next enable period starts from a fresh minimum off time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Charging mode from the mode controller |
| peakHit | input | 1 | Primary current at its peak limit |
| valleyLow | input | 1 | Secondary current below its floor |
| vdetRaw | input | 1 | Unqualified output-voltage-reached comparator |
| gateOn | output | 1 | Power switch gate drive |
| targetReached | output | 1 | One-cycle pulse on a qualified voltage detect |

## Verification
The stimulus runs several patterns. Valley held high from start-up separates the minimum off time from an immediate turn-on. Detect pulses while the gate is on, and others inside the blanking window, separate a correctly masked comparator from a leaky one. Peak and valley held together show whether turn-off has priority. After a late detect, valley is held high to show that switching stays halted. Enable is dropped while the gate is on, which shows the gate falls at once and the off timer restarts.

// File: rtl/flyback_pkg.sv
package flyback_pkg;
  // strobes from the control into the timing datapath
  typedef struct packed {
    logic clear;     // enable low: wipe counters
    logic turnOff;   // gate falls at this edge: load blanking
    logic gateIsOn;  // gate state, resets off-time count
  } ctrlStrobe_t;

  // status from the datapath back to the control
  typedef struct packed {
    logic offDone;     // minimum off time satisfied
    logic blankActive; // detect comparator masked
  } dpStatus_t;
endpackage

// File: rtl/flyback_timing_dp.sv
module flyback_timing_dp
  import flyback_pkg::*;
#(
  parameter int MIN_OFF_CYCLES = 100,
  parameter int BLANK_CYCLES   = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);
  localparam int OFF_W     = (MIN_OFF_CYCLES < 2) ? 1 : $clog2(MIN_OFF_CYCLES + 1);
  localparam int OFF_LIMIT = MIN_OFF_CYCLES - 1;

  logic [OFF_W-1:0] offCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      offCnt <= '0;
    end else if (strobe.gateIsOn) begin
      offCnt <= '0;
    end else if (offCnt != OFF_W'(MIN_OFF_CYCLES)) begin
      offCnt <= offCnt + 1'b1;
    end
  end

  assign status.offDone = (offCnt >= OFF_W'(OFF_LIMIT));

  generate
    if (BLANK_CYCLES == 0) begin : gNoBlank
      assign status.blankActive = 1'b0;
    end else begin : gBlank
      localparam int BLANK_W = $clog2(BLANK_CYCLES + 1);
      logic [BLANK_W-1:0] blankCnt;
      always_ff @(posedge clk) begin
        if (!rstN || strobe.clear) begin
          blankCnt <= '0;
        end else if (strobe.turnOff) begin
          blankCnt <= BLANK_W'(BLANK_CYCLES);
        end else if (blankCnt != '0) begin
          blankCnt <= blankCnt - 1'b1;
        end
      end
      assign status.blankActive = (blankCnt != '0);
    end
  endgenerate
endmodule

// File: rtl/flyback_gate_ctrl.sv
module flyback_gate_ctrl
  import flyback_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        peakHit,
  input  logic        valleyLow,
  input  logic        vdetRaw,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        gateQ,
  output logic        reachedQ
);
  logic haltQ;
  logic running;
  logic qualify;
  logic turnOffEv;
  logic turnOnEv;

  always_comb begin
    running   = enable && !haltQ;
    qualify   = running && vdetRaw && !gateQ && !status.blankActive;
    turnOffEv = running && !qualify && gateQ && peakHit;
    turnOnEv  = running && !qualify && !gateQ && valleyLow && !peakHit && status.offDone;
    strobe.clear    = !enable;
    strobe.turnOff  = turnOffEv;
    strobe.gateIsOn = gateQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      gateQ    <= 1'b0;
      haltQ    <= 1'b0;
      reachedQ <= 1'b0;
    end else begin
      reachedQ <= qualify;
      if (qualify) begin
        gateQ <= 1'b0;
        haltQ <= 1'b1;
      end else if (turnOffEv) begin
        gateQ <= 1'b0;
      end else if (turnOnEv) begin
        gateQ <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flyback_cycle_ctrl.sv
module flyback_cycle_ctrl
  import flyback_pkg::*;
#(
  parameter int MIN_OFF_CYCLES = 100,
  parameter int BLANK_CYCLES   = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic peakHit,
  input  logic valleyLow,
  input  logic vdetRaw,
  output logic gateOn,
  output logic targetReached
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  logic        gateQ;
  logic        reachedQ;

  flyback_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .peakHit(peakHit),
    .valleyLow(valleyLow), .vdetRaw(vdetRaw), .status(status),
    .strobe(strobe), .gateQ(gateQ), .reachedQ(reachedQ)
  );

  flyback_timing_dp #(
    .MIN_OFF_CYCLES(MIN_OFF_CYCLES), .BLANK_CYCLES(BLANK_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status)
  );

  assign gateOn        = gateQ && enable;
  assign targetReached = reachedQ;
endmodule

// File: rtl/flyback_cycle_ctrl_chk.sv
module flyback_cycle_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic peakHit,
  input logic valleyLow,
  input logic gateOn,
  input logic targetReached
);
  // R3
  peak_turns_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateOn && peakHit |=> !gateOn);

  // R4
  peak_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gateOn && peakHit |=> !gateOn);

  // R2
  rise_needs_valley_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> $past(valleyLow) && $past(enable));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    targetReached |=> !targetReached);

  // R8
  reached_gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    targetReached |-> !gateOn);

  // R9
  enable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !gateOn && !targetReached);
endmodule

bind flyback_cycle_ctrl flyback_cycle_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .peakHit(peakHit),
  .valleyLow(valleyLow), .gateOn(gateOn), .targetReached(targetReached)
);

// File: tb/flyback_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module flyback_cycle_ctrl_bench;
  localparam int MIN_OFF = 100;
  localparam int BLANK   = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, peakHit = 1'b0, valleyLow = 1'b0, vdetRaw = 1'b0;
  logic gateOn, targetReached;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model state
  int mGate = 0, mOff = 0, mBlank = 0, mHalt = 0, mPulse = 0;

  always #2.5 clk = ~clk;

  flyback_cycle_ctrl #(.MIN_OFF_CYCLES(MIN_OFF), .BLANK_CYCLES(BLANK)) u_flyback_cycle_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .peakHit(peakHit),
    .valleyLow(valleyLow), .vdetRaw(vdetRaw), .gateOn(gateOn),
    .targetReached(targetReached)
  );

  always @(posedge clk) begin
    int nGate, nOff, nBlank, nHalt, nPulse;
    bit q;
    if (!rstN || !enable) begin
      mGate = 0; mOff = 0; mBlank = 0; mHalt = 0; mPulse = 0;
    end else begin
      nGate = mGate; nHalt = mHalt;
      nOff = mGate ? 0 : ((mOff < MIN_OFF) ? mOff + 1 : mOff);
      nBlank = (mBlank > 0) ? mBlank - 1 : 0;
      q = (mHalt == 0) && vdetRaw && (mGate == 0) && (mBlank == 0);
      nPulse = q;
      if (mHalt == 0) begin
        if (q) begin nGate = 0; nHalt = 1; end
        else if (mGate == 1 && peakHit) begin nGate = 0; nBlank = BLANK; end
        else if (mGate == 0 && valleyLow && !peakHit && mOff >= MIN_OFF - 1) nGate = 1;
      end
      mGate = nGate; mOff = nOff; mBlank = nBlank; mHalt = nHalt; mPulse = nPulse;
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // model comparison on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check({phase, " gateOn"}, gateOn, (mGate == 1) && enable);
      check({phase, " targetReached"}, targetReached, mPulse == 1);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    step(3);
    check("R1 reset gate", gateOn, 1'b0);
    check("R1 reset reached", targetReached, 1'b0);
    rstN = 1'b1;
    step(1);
    check("R1 post-reset gate", gateOn, 1'b0);

    phase = "R5"; enable = 1'b1; valleyLow = 1'b1;
    step(50);
    check("R5 min off at start", gateOn, 1'b0);
    phase = "R2"; step(70);
    check("R2 turn-on after off time", gateOn, 1'b1);

    phase = "R7"; vdetRaw = 1'b1; valleyLow = 1'b0;
    step(5);
    check("R7 detect ignored while on", targetReached, 1'b0);
    check("R7 gate still on", gateOn, 1'b1);
    vdetRaw = 1'b0;

    phase = "R3"; peakHit = 1'b1;
    step(1);
    check("R3 off after peak", gateOn, 1'b0);
    peakHit = 1'b0;

    phase = "R6"; vdetRaw = 1'b1;
    step(BLANK - 2);
    check("R6 detect blanked", targetReached, 1'b0);
    vdetRaw = 1'b0;

    phase = "R4"; peakHit = 1'b1; valleyLow = 1'b1;
    step(150);
    check("R4 peak beats valley", gateOn, 1'b0);
    peakHit = 1'b0;
    step(2);
    check("R2 turn-on once peak clears", gateOn, 1'b1);

    phase = "R8"; valleyLow = 1'b0; peakHit = 1'b1;
    step(1);
    peakHit = 1'b0;
    step(BLANK + 5);
    vdetRaw = 1'b1;
    step(1);
    check("R8 pulse after qualified detect", targetReached, 1'b1);
    vdetRaw = 1'b0; valleyLow = 1'b1;
    step(1);
    check("R8 pulse one cycle", targetReached, 1'b0);
    step(200);
    check("R8 halted despite valley", gateOn, 1'b0);

    phase = "R9"; enable = 1'b0;
    step(2);
    enable = 1'b1;
    step(120);
    check("R9 restart after re-enable", gateOn, 1'b1);
    enable = 1'b0;
    #1;
    check("R9 gate drops with enable", gateOn, 1'b0);
    step(1);
    enable = 1'b1;
    step(50);
    check("R9 off time restarted", gateOn, 1'b0);
    step(70);
    check("R9 on after fresh off time", gateOn, 1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule